// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block produces the condition flags that follow an 8-bit or 16-bit addition or subtraction and keeps them in a registered 16-bit status word. Each cycle, the surrounding datapath presents both operands, the operation, the operand size and the result that its adder produced. When the update strobe is high, the block recomputes six condition flags and writes them into their fixed positions in the status word. Every other bit of the word keeps its value.

A separate load path replaces the whole word in one cycle. The datapath uses it to restore a saved status word, and through it the control bits get their values. When a load and an update arrive in the same cycle, the load wins. In byte mode, only the low eight bits of the operands and the result are examined.

Top module: `arith_status_flags`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, status_q reads 16'h0000.
- R2: Bit 0 (carry) is set after an update when an add carries out of the top bit of the operand size, or when a subtract needs a borrow (unsigned opnd_a < opnd_b over the operand size).
- R3: Bit 2 (parity) is set after an update when result[7:0] holds an even number of 1 bits. This is independent of the size.
- R4: Bit 4 (auxiliary carry) is set after an update when the add carries, or the subtract borrows, between bit 3 and bit 4. Equivalently, it is bit 4 of opnd_a ^ opnd_b ^ result.
- R5: Bit 6 (zero) is set after an update when the result over the operand size equals zero.
- R6: Bit 7 (sign) takes the top bit of the result over the operand size (bit 7 in byte mode, bit 15 in word mode).
- R7: Bit 11 (overflow) is set after an update on signed overflow. For an add, both operands have the same sign and the result's sign differs from it. For a subtract, the operand signs differ and the result's sign differs from opnd_a's sign.
- R8: When size_word is 0, bits 15:8 of opnd_a, opnd_b and result have no effect on any flag.
- R9: An update leaves bits 1, 3, 5, 8, 9, 10 and 12 to 15 of status_q unchanged.
- R10: When neither upd_en nor ld_en is high, status_q holds its value.
- R11: When ld_en is high, status_q takes ld_word on the next edge, whatever upd_en is.
- R12: The status word changes one clock edge after the inputs are sampled. op_sub=1 selects subtract and size_word=1 selects 16-bit operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_en | input | 1 | Recompute the arithmetic flags this cycle |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| size_word | input | 1 | 1 = 16-bit operands, 0 = 8-bit operands |
| opnd_a | input | 16 | First operand (minuend for a subtract) |
| opnd_b | input | 16 | Second operand (subtrahend for a subtract) |
| result | input | 16 | Result produced by the datapath |
| ld_en | input | 1 | Load the full status word |
| ld_word | input | 16 | Value to load |
| status_q | output | 16 | Registered status word |

## Verification
The hardest situation to reach is a byte-mode update whose upper operand and result bits would, if looked at, flip the carry, overflow, zero or sign decision. The stimulus covers it by filling bits 15:8 with random values on every byte operation. The second hard case is an update that starts from a word whose control bits are all ones. Those bits only hold their value if a load has set them first, so the stimulus loads random and all-ones words between bursts of updates. Boundary operands such as 7F+1, FF+1, 0-1, 7FFF+1 and 8000-1 are applied as directed cases. Random traffic follows, with a reference model compared on every clock.

// File: rtl/flag_pkg.sv
package flag_pkg;
    localparam int STAT_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int DATA_W  = 16;
    localparam int POS_CF  = 0;
    localparam int POS_PF  = 2;
    localparam int POS_AF  = 4;
    localparam int POS_ZF  = 6;
    localparam int POS_SF  = 7;
    localparam int POS_OF  = 11;
    localparam logic [STAT_W-1:0] ARITH_MASK =
        STAT_W'((1 << POS_CF) | (1 << POS_PF) | (1 << POS_AF) |
                (1 << POS_ZF) | (1 << POS_SF) | (1 << POS_OF));

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } arith_flags_t;
endpackage

// File: rtl/flag_lane.sv
module flag_lane
    import flag_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [W-1:0]  r,
    input  logic          sub,
    output arith_flags_t  f
);
    localparam int MSB = W - 1;

    always_comb begin
        // carry out of an add happens exactly when a exceeds the complement of b
        f.cf = sub ? (a < b) : (a > ~b);
        f.pf = ~^r[BYTE_W-1:0];
        f.af = a[4] ^ b[4] ^ r[4];
        f.zf = (r == '0);
        f.sf = r[MSB];
        if (sub)
            f.of = (a[MSB] != b[MSB]) && (r[MSB] != a[MSB]);
        else
            f.of = (a[MSB] == b[MSB]) && (r[MSB] != a[MSB]);
    end
endmodule

// File: rtl/arith_status_flags.sv
module arith_status_flags
    import flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic              op_sub,
    input  logic              size_word,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] result,
    input  logic              ld_en,
    input  logic [STAT_W-1:0] ld_word,
    output logic [STAT_W-1:0] status_q
);
    localparam int N_LANES = 2;

    typedef struct packed {
        logic [STAT_W-1:0] word;
    } state_t;

    state_t       st_d, st_q;
    arith_flags_t lane_f [N_LANES];
    arith_flags_t sel_f;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? BYTE_W : DATA_W;
        flag_lane #(.W(LW)) u_lane (
            .a   (opnd_a[LW-1:0]),
            .b   (opnd_b[LW-1:0]),
            .r   (result[LW-1:0]),
            .sub (op_sub),
            .f   (lane_f[g])
        );
    end

    always_comb begin
        sel_f = size_word ? lane_f[1] : lane_f[0];
        st_d  = st_q;
        if (ld_en) begin
            st_d.word = ld_word;
        end else if (upd_en) begin
            st_d.word[POS_CF] = sel_f.cf;
            st_d.word[POS_PF] = sel_f.pf;
            st_d.word[POS_AF] = sel_f.af;
            st_d.word[POS_ZF] = sel_f.zf;
            st_d.word[POS_SF] = sel_f.sf;
            st_d.word[POS_OF] = sel_f.of;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_q = st_q.word;

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !upd_en) |=> $stable(status_q));

    p_keep_other_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !ld_en) |=>
            ((status_q & ~ARITH_MASK) == ($past(status_q) & ~ARITH_MASK)));

    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (status_q == $past(ld_word)));

    p_parity_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !ld_en) |=>
            (status_q[POS_PF] == ($countones($past(result[BYTE_W-1:0])) % 2 == 0)));

    p_byte_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !ld_en && !size_word) |=>
            (status_q[POS_ZF] == ($past(result[BYTE_W-1:0]) == '0)));

    p_word_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !ld_en && size_word) |=>
            (status_q[POS_SF] == $past(result[DATA_W-1])));
endmodule

// File: tb/test_arith_status_flags.sv
module test_arith_status_flags;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0, op_sub = 1'b0, size_word = 1'b0, ld_en = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0, result = '0, ld_word = '0;
    logic [15:0] status_q;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_w   = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    arith_status_flags i_arith_status_flags (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_sub(op_sub),
        .size_word(size_word), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .result(result), .ld_en(ld_en), .ld_word(ld_word), .status_q(status_q)
    );

    task automatic chk_bit(input int pos, input string req);
        n_tests++;
        if (status_q[pos] !== exp_w[pos]) begin
            n_fail++;
            $display("FAIL %s bit %0d: got %0b expected %0b (word %h vs %h)",
                     req, pos, status_q[pos], exp_w[pos], status_q, exp_w[15:0]);
        end
    endtask

    task automatic chk_all(input string ctx);
        chk_bit(0, "R2 carry");
        chk_bit(2, "R3 parity");
        chk_bit(4, "R4 aux");
        chk_bit(6, "R5 zero");
        chk_bit(7, "R6 sign");
        chk_bit(11, "R7 overflow");
        n_tests++;
        if ((status_q & 16'hF72A) !== (exp_w[15:0] & 16'hF72A)) begin
            n_fail++;
            $display("FAIL R9/R10/R11 %s other bits: got %h expected %h",
                     ctx, status_q & 16'hF72A, exp_w[15:0] & 16'hF72A);
        end
    endtask

    // Reference: R2..R8 behaviour computed with plain integers
    function automatic int model_upd(input int old, input int a_in, input int b_in,
                                     input int r_in, input bit sub, input bit wrd);
        int w, mask, a, b, r, sa, sb, sr, ones, nw;
        w = wrd ? 16 : 8;
        mask = (1 << w) - 1;
        a = a_in & mask; b = b_in & mask; r = r_in & mask;
        sa = (a >> (w-1)) & 1; sb = (b >> (w-1)) & 1; sr = (r >> (w-1)) & 1;
        nw = old & ~((1<<0)|(1<<2)|(1<<4)|(1<<6)|(1<<7)|(1<<11));
        if (sub) begin
            if (a < b) nw |= 1;
            if (sa != sb && sr != sa) nw |= (1 << 11);
        end else begin
            if (a + b > mask) nw |= 1;
            if (sa == sb && sr != sa) nw |= (1 << 11);
        end
        ones = 0;
        for (int i = 0; i < 8; i++) ones += (r_in >> i) & 1;
        if (ones % 2 == 0) nw |= (1 << 2);
        if (((a ^ b ^ r) >> 4) & 1) nw |= (1 << 4);
        if (r == 0) nw |= (1 << 6);
        if (sr) nw |= (1 << 7);
        return nw;
    endfunction

    // Drive one cycle; sample after the edge, away from it (R12)
    task automatic step(input bit up, input bit sub, input bit wrd,
                        input int a, input int b, input bit ld, input int lw,
                        input bit rand_hi, input string ctx);
        int r;
        @(negedge clk);
        r = sub ? (a - b) : (a + b);
        if (!wrd) begin
            r = r & 16'h00FF;
            if (rand_hi) r |= ($urandom & 16'hFF00);
        end
        upd_en = up; op_sub = sub; size_word = wrd;
        opnd_a = a[15:0]; opnd_b = b[15:0]; result = r[15:0];
        ld_en = ld; ld_word = lw[15:0];
        if (ld)      exp_w = lw & 16'hFFFF;
        else if (up) exp_w = model_upd(exp_w, a, b, r, sub, wrd);
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk_all(ctx);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_tests++;
        if (status_q !== 16'h0000) begin
            n_fail++;
            $display("FAIL R1 reset: got %h expected 0000", status_q);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        n_tests++;
        if (status_q !== 16'h0000) begin
            n_fail++;
            $display("FAIL R1 after release: got %h expected 0000", status_q);
        end

        // directed boundaries (R2, R4, R5, R6, R7)
        step(1, 0, 0, 'h7F, 'h01, 0, 0, 0, "byte 7F+1");
        step(1, 0, 0, 'hFF, 'h01, 0, 0, 0, "byte FF+1");
        step(1, 1, 0, 'h00, 'h01, 0, 0, 0, "byte 0-1");
        step(1, 1, 0, 'h80, 'h01, 0, 0, 0, "byte 80-1");
        step(1, 0, 1, 'h7FFF, 'h0001, 0, 0, 0, "word 7FFF+1");
        step(1, 1, 1, 'h8000, 'h0001, 0, 0, 0, "word 8000-1");
        step(1, 0, 1, 'hFFFF, 'h0001, 0, 0, 0, "word FFFF+1");
        step(1, 1, 1, 'h1234, 'h1234, 0, 0, 0, "word equal sub");
        // R8: upper bits set would flip word decisions
        step(1, 0, 0, 'hFF00, 'hFF00, 0, 0, 1, "byte upper junk");
        step(1, 1, 0, 'h1205, 'hF005, 0, 0, 1, "byte sub junk");
        // R11 load, then R9 preservation with all-ones
        step(0, 0, 0, 0, 0, 1, 'hFFFF, 0, "load ones");
        step(1, 0, 1, 'h0001, 'h0001, 0, 0, 0, "keep ones");
        step(1, 0, 0, 'h0000, 'h0000, 1, 'h0A5A, 0, "load beats update");
        // R10 idle hold
        step(0, 1, 1, 'hFFFF, 'h1111, 0, 0, 0, "idle");

        for (int k = 0; k < N_RANDOM; k++) begin
            int sel = $urandom_range(0, 9);
            step(sel != 0, $urandom_range(0, 1), $urandom_range(0, 1),
                 $urandom & 16'hFFFF, $urandom & 16'hFFFF,
                 sel == 9, $urandom & 16'hFFFF, 1, "random");
        end
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule